// File: doc/BRIEF.md
# Store Queue with Retirement-Driven Senior Marking

This block keeps in-flight stores in program order between allocation and their write to the data cache. Each store takes one slot when it is allocated. The slot index is returned to the pipeline and names both halves of the store until it leaves: the address half and the data half. The slot also records the store's reorder-buffer tag. The address-generation side writes the address for a slot. The translation side writes the physical tag for the same slot. The data side writes the store value directly. These three writes can arrive in any order.

Every cycle, the retirement stage presents three reorder-buffer tags. These name the three oldest unretired uops, and each tag has a ready bit. A queued store whose tag matches an enabled pointer becomes senior, which marks both of its halves. The oldest entry leaves through a valid/ready cache port once it is senior and its address, physical tag and data are all present. A store fence is granted only when the queue is empty. A flush removes every speculative (non-senior) store and keeps the senior ones.

Top module: `store_queue`

## Requirements
- R1: `alloc_ok` is high exactly when `alloc_req` and `alloc_ext_avail` are high, `full` is low and `flush` is low. The slot granted is `alloc_id`. After reset, grants go to slots 0, 1, 2, ... and wrap modulo DEPTH.
- R2: After reset, `empty` is 1, `full` is 0 and `dc_valid` is 0.
- R3: `full` is 1 when DEPTH entries are held and `empty` is 1 when no entry is held. No slot is granted while the queue is full.
- R4: The address, physical tag and data of a slot are written by `sta_wr_en`, `tlb_wr_en` and `std_wr_en` with their slot ids, in any order. A senior entry that lacks any one of the three is not offered to the cache.
- R5: `ret_rdy[0]` belongs to the oldest pointer `ret_tag0`, `ret_rdy[1]` to `ret_tag1` and `ret_rdy[2]` to `ret_tag2`. When `ret_rdy` is 3'b001, 3'b011 or 3'b111, every held entry whose tag equals a pointer with its ready bit set becomes senior on the next clock edge.
- R6: Any other `ret_rdy` pattern (3'b010, 3'b100, 3'b101, 3'b110) causes no entry to become senior.
- R7: Entries leave strictly in allocation order, at most one per cycle. `dc_valid` is high only for a senior, complete oldest entry. While `dc_ready` is low, `dc_valid` and the payload hold steady.
- R8: `fence_ok` is high exactly when `fence_req` is high and the queue is empty.
- R9: `flush` drops every non-senior entry and moves the tail to just after the youngest senior entry, so the next grant reuses that slot. The senior entries still drain.
- R10: The senior marks on the address half and the data half of a slot are always set and cleared together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a slot for a new store |
| alloc_ext_avail | input | 1 | All other pipeline resources for the store are free |
| alloc_rob_tag | input | TAG_W | Reorder-buffer tag of the store |
| alloc_ok | output | 1 | Slot granted this cycle |
| alloc_id | output | IDX_W | Granted slot index |
| sta_wr_en | input | 1 | Address write |
| sta_wr_id | input | IDX_W | Slot of the address write |
| sta_wr_addr | input | ADDR_W | Store address |
| tlb_wr_en | input | 1 | Physical tag write |
| tlb_wr_id | input | IDX_W | Slot of the physical tag write |
| tlb_wr_ptag | input | PTAG_W | Translated physical tag |
| std_wr_en | input | 1 | Data write |
| std_wr_id | input | IDX_W | Slot of the data write |
| std_wr_data | input | DATA_W | Store data |
| ret_tag0 | input | TAG_W | Oldest retirement pointer |
| ret_tag1 | input | TAG_W | Second retirement pointer |
| ret_tag2 | input | TAG_W | Third retirement pointer |
| ret_rdy | input | 3 | Ready bits, bit 0 for the oldest pointer |
| dc_valid | output | 1 | Oldest store offered to the cache |
| dc_ready | input | 1 | Cache accepts the offered store |
| dc_addr | output | ADDR_W | Address of the offered store |
| dc_ptag | output | PTAG_W | Physical tag of the offered store |
| dc_data | output | DATA_W | Data of the offered store |
| fence_req | input | 1 | Store fence waiting for dispatch |
| fence_ok | output | 1 | Store fence may proceed |
| flush | input | 1 | Discard all speculative stores |
| full | output | 1 | All slots held |
| empty | output | 1 | No slot held |

## Verification
The hardest case to reach is a flush that arrives while the queue is full and wrapped. In that state the oldest stores are senior and waiting for the cache, and the younger ones are still speculative. The flush must then land the tail in the middle of the ring. To get there, the stimulus first runs earlier stores through the queue so that the head is no longer at slot 0. It then fills every slot, completes and retires only the two oldest with a two-pointer ready pattern, and raises the flush. It checks the slot of the next grant, and then drains the two survivors in order.

// File: rtl/stq_pkg.sv
package stq_pkg;
   localparam int STQ_NUM_RET = 3;

   typedef struct packed {
      logic vld;
      logic a_vld;
      logic p_vld;
      logic d_vld;
      logic sen_a;
      logic sen_d;
   } stq_flags_t;

   // Retirement must stay contiguous from the oldest pointer (bit 0).
   function automatic logic ret_pattern_ok(input logic [STQ_NUM_RET-1:0] rdy);
      return (rdy == 3'b001) || (rdy == 3'b011) || (rdy == 3'b111);
   endfunction
endpackage

// File: rtl/stq_retire_gate.sv
module stq_retire_gate
   import stq_pkg::*;
(
   input  logic [STQ_NUM_RET-1:0] ret_rdy,
   output logic [STQ_NUM_RET-1:0] ret_en
);
   always_comb begin
      ret_en = ret_pattern_ok(ret_rdy) ? ret_rdy : '0;
   end
endmodule

// File: rtl/stq_entry.sv
module stq_entry
   import stq_pkg::*;
#(
   parameter int TAG_W  = 7,
   parameter int ADDR_W = 12,
   parameter int PTAG_W = 20,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_we,
   input  logic [TAG_W-1:0]             alloc_tag,
   input  logic                         sta_we,
   input  logic [ADDR_W-1:0]            sta_addr,
   input  logic                         tlb_we,
   input  logic [PTAG_W-1:0]            tlb_ptag,
   input  logic                         std_we,
   input  logic [DATA_W-1:0]            std_data,
   input  logic [STQ_NUM_RET*TAG_W-1:0] ret_tags,
   input  logic [STQ_NUM_RET-1:0]       ret_en,
   input  logic                         kill_spec,
   input  logic                         drain_clr,
   output stq_flags_t                   flags_o,
   output logic [ADDR_W-1:0]            addr_o,
   output logic [PTAG_W-1:0]            ptag_o,
   output logic [DATA_W-1:0]            data_o
);
   stq_flags_t        flags_q;
   logic [TAG_W-1:0]  tag_q;
   logic              hit;

   always_comb begin
      hit = 1'b0;
      for (int r = 0; r < STQ_NUM_RET; r++) begin
         if (ret_en[r] && (ret_tags[r*TAG_W +: TAG_W] == tag_q)) hit = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         tag_q   <= '0;
      end else if (alloc_we) begin
         flags_q     <= '0;
         flags_q.vld <= 1'b1;
         tag_q       <= alloc_tag;
      end else if (drain_clr || (kill_spec && !flags_q.sen_a)) begin
         flags_q <= '0;
      end else if (flags_q.vld) begin
         if (sta_we) flags_q.a_vld <= 1'b1;
         if (tlb_we) flags_q.p_vld <= 1'b1;
         if (std_we) flags_q.d_vld <= 1'b1;
         if (hit && !flags_q.sen_a) begin
            flags_q.sen_a <= 1'b1;
            flags_q.sen_d <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (sta_we) addr_o <= sta_addr;
      if (tlb_we) ptag_o <= tlb_ptag;
      if (std_we) data_o <= std_data;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/store_queue.sv
module store_queue
   import stq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 7,
   parameter int ADDR_W = 12,
   parameter int PTAG_W = 20,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic              alloc_ext_avail,
   input  logic [TAG_W-1:0]  alloc_rob_tag,
   output logic              alloc_ok,
   output logic [IDX_W-1:0]  alloc_id,
   input  logic              sta_wr_en,
   input  logic [IDX_W-1:0]  sta_wr_id,
   input  logic [ADDR_W-1:0] sta_wr_addr,
   input  logic              tlb_wr_en,
   input  logic [IDX_W-1:0]  tlb_wr_id,
   input  logic [PTAG_W-1:0] tlb_wr_ptag,
   input  logic              std_wr_en,
   input  logic [IDX_W-1:0]  std_wr_id,
   input  logic [DATA_W-1:0] std_wr_data,
   input  logic [TAG_W-1:0]  ret_tag0,
   input  logic [TAG_W-1:0]  ret_tag1,
   input  logic [TAG_W-1:0]  ret_tag2,
   input  logic [2:0]        ret_rdy,
   output logic              dc_valid,
   input  logic              dc_ready,
   output logic [ADDR_W-1:0] dc_addr,
   output logic [PTAG_W-1:0] dc_ptag,
   output logic [DATA_W-1:0] dc_data,
   input  logic              fence_req,
   output logic              fence_ok,
   input  logic              flush,
   output logic              full,
   output logic              empty
);
   localparam int CNT_W = IDX_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("store_queue: DEPTH must be a power of two, at least 2");
   end
   if (TAG_W < 1 || ADDR_W < 1 || PTAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("store_queue: field widths must be positive");
   end

   logic [IDX_W-1:0]        head, tail;
   logic [CNT_W-1:0]        cnt, sen_cnt;
   logic [STQ_NUM_RET-1:0]  ret_en;
   stq_flags_t              ent_flags [DEPTH];
   logic [ADDR_W-1:0]       ent_addr  [DEPTH];
   logic [PTAG_W-1:0]       ent_ptag  [DEPTH];
   logic [DATA_W-1:0]       ent_data  [DATA_W > 0 ? DEPTH : 1];
   logic [DEPTH-1:0]        vld_vec, sen_a_vec, sen_d_vec;
   stq_flags_t              hd;
   logic                    drain;

   stq_retire_gate u_gate (.ret_rdy(ret_rdy), .ret_en(ret_en));

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      stq_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .PTAG_W(PTAG_W), .DATA_W(DATA_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_we  (alloc_ok && (tail == IDX_W'(i))),
         .alloc_tag (alloc_rob_tag),
         .sta_we    (sta_wr_en && (sta_wr_id == IDX_W'(i))),
         .sta_addr  (sta_wr_addr),
         .tlb_we    (tlb_wr_en && (tlb_wr_id == IDX_W'(i))),
         .tlb_ptag  (tlb_wr_ptag),
         .std_we    (std_wr_en && (std_wr_id == IDX_W'(i))),
         .std_data  (std_wr_data),
         .ret_tags  ({ret_tag2, ret_tag1, ret_tag0}),
         .ret_en    (ret_en),
         .kill_spec (flush),
         .drain_clr (drain && (head == IDX_W'(i))),
         .flags_o   (ent_flags[i]),
         .addr_o    (ent_addr[i]),
         .ptag_o    (ent_ptag[i]),
         .data_o    (ent_data[i])
      );
      assign vld_vec[i]   = ent_flags[i].vld;
      assign sen_a_vec[i] = ent_flags[i].sen_a;
      assign sen_d_vec[i] = ent_flags[i].sen_d;
   end

   always_comb begin
      sen_cnt = '0;
      for (int i = 0; i < DEPTH; i++) sen_cnt = sen_cnt + CNT_W'(sen_a_vec[i]);
   end

   assign full     = (cnt == CNT_W'(DEPTH));
   assign empty    = (cnt == '0);
   assign alloc_ok = alloc_req && alloc_ext_avail && !full && !flush;
   assign alloc_id = tail;
   assign fence_ok = fence_req && empty;

   assign hd       = ent_flags[head];
   assign dc_valid = hd.vld && hd.sen_a && hd.sen_d && hd.a_vld && hd.p_vld && hd.d_vld;
   assign dc_addr  = ent_addr[head];
   assign dc_ptag  = ent_ptag[head];
   assign dc_data  = ent_data[head];
   assign drain    = dc_valid && dc_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         head <= head + IDX_W'(drain);
         if (flush) begin
            tail <= head + sen_cnt[IDX_W-1:0];
            cnt  <= sen_cnt - CNT_W'(drain);
         end else begin
            tail <= tail + IDX_W'(alloc_ok);
            cnt  <= cnt + CNT_W'(alloc_ok) - CNT_W'(drain);
         end
      end
   end
endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 12,
   parameter int PTAG_W = 20,
   parameter int DATA_W = 32,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_ok,
   input logic              full,
   input logic              empty,
   input logic [CNT_W-1:0]  cnt,
   input logic              dc_valid,
   input logic              dc_ready,
   input logic [ADDR_W-1:0] dc_addr,
   input logic [PTAG_W-1:0] dc_ptag,
   input logic [DATA_W-1:0] dc_data,
   input logic              fence_req,
   input logic              fence_ok,
   input logic              flush,
   input logic [DEPTH-1:0]  vld_vec,
   input logic [DEPTH-1:0]  sen_a_vec,
   input logic [DEPTH-1:0]  sen_d_vec
);
   assert_alloc_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |=> !empty);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   assert_no_alloc_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !alloc_ok);
   assert_offer_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dc_valid |-> !empty);
   assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_valid && !dc_ready) |=> (dc_valid && $stable(dc_addr) && $stable(dc_ptag) && $stable(dc_data)));
   assert_fence_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ok |-> (fence_req && empty));
   assert_flush_spec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ((vld_vec & ~sen_a_vec) == '0));
   assert_senior_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sen_a_vec == sen_d_vec);
endmodule

bind store_queue stq_checker #(
   .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTAG_W(PTAG_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_ok(alloc_ok), .full(full), .empty(empty),
   .cnt(cnt), .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_addr(dc_addr),
   .dc_ptag(dc_ptag), .dc_data(dc_data), .fence_req(fence_req), .fence_ok(fence_ok),
   .flush(flush), .vld_vec(vld_vec), .sen_a_vec(sen_a_vec), .sen_d_vec(sen_d_vec)
);

// File: tb/store_queue_tb.sv
module store_queue_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8, TAG_W = 7, ADDR_W = 12, PTAG_W = 20, DATA_W = 32;
   localparam int IDX_W = 3;

   logic clk = 0, rst_n = 0;
   logic alloc_req = 0, alloc_ext_avail = 1;
   logic [TAG_W-1:0] alloc_rob_tag = '0;
   logic alloc_ok;
   logic [IDX_W-1:0] alloc_id;
   logic sta_wr_en = 0, tlb_wr_en = 0, std_wr_en = 0;
   logic [IDX_W-1:0] sta_wr_id = '0, tlb_wr_id = '0, std_wr_id = '0;
   logic [ADDR_W-1:0] sta_wr_addr = '0;
   logic [PTAG_W-1:0] tlb_wr_ptag = '0;
   logic [DATA_W-1:0] std_wr_data = '0;
   logic [TAG_W-1:0] ret_tag0 = '0, ret_tag1 = '0, ret_tag2 = '0;
   logic [2:0] ret_rdy = '0;
   logic dc_valid, dc_ready = 0;
   logic [ADDR_W-1:0] dc_addr;
   logic [PTAG_W-1:0] dc_ptag;
   logic [DATA_W-1:0] dc_data;
   logic fence_req = 0, fence_ok, flush = 0, full, empty;

   int n_chk = 0, n_fail = 0;
   logic [IDX_W-1:0] exp_tail = '0;

   store_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .PTAG_W(PTAG_W), .DATA_W(DATA_W)) u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_alloc(input logic [TAG_W-1:0] tag, input logic exp_ok, input string req);
      alloc_req = 1; alloc_rob_tag = tag; #1;
      chk(alloc_ok == exp_ok, req, alloc_ok, exp_ok);
      if (exp_ok) chk(alloc_id == exp_tail, req, alloc_id, exp_tail);
      tick(); alloc_req = 0;
      if (exp_ok) exp_tail = exp_tail + 1'b1;
   endtask

   task automatic wr_sta(input logic [IDX_W-1:0] id, input logic [ADDR_W-1:0] a);
      sta_wr_en = 1; sta_wr_id = id; sta_wr_addr = a; tick(); sta_wr_en = 0;
   endtask
   task automatic wr_tlb(input logic [IDX_W-1:0] id, input logic [PTAG_W-1:0] p);
      tlb_wr_en = 1; tlb_wr_id = id; tlb_wr_ptag = p; tick(); tlb_wr_en = 0;
   endtask
   task automatic wr_std(input logic [IDX_W-1:0] id, input logic [DATA_W-1:0] d);
      std_wr_en = 1; std_wr_id = id; std_wr_data = d; tick(); std_wr_en = 0;
   endtask
   task automatic fill_all(input logic [IDX_W-1:0] id, input logic [7:0] k);
      sta_wr_en = 1; sta_wr_id = id; sta_wr_addr = {4'h0, k};
      tlb_wr_en = 1; tlb_wr_id = id; tlb_wr_ptag = {12'h0, k};
      std_wr_en = 1; std_wr_id = id; std_wr_data = {24'h0, k};
      tick();
      sta_wr_en = 0; tlb_wr_en = 0; std_wr_en = 0;
   endtask
   task automatic retire(input logic [TAG_W-1:0] t0, input logic [TAG_W-1:0] t1, input logic [2:0] rdy);
      ret_tag0 = t0; ret_tag1 = t1; ret_tag2 = t1 + 1'b1; ret_rdy = rdy; tick(); ret_rdy = 0;
   endtask
   task automatic expect_drain(input logic [7:0] k, input string req);
      chk(dc_valid === 1'b1, req, dc_valid, 1);
      chk(dc_addr == {4'h0, k} && dc_data == {24'h0, k} && dc_ptag == {12'h0, k}, req, dc_addr, k);
      dc_ready = 1; tick(); dc_ready = 0;
   endtask

   task automatic t_reset();
      chk(empty === 1'b1, "R2 empty", empty, 1);
      chk(full === 1'b0, "R2 full", full, 0);
      chk(dc_valid === 1'b0, "R2 dc_valid", dc_valid, 0);
   endtask

   task automatic t_basic();
      do_alloc(7'd5, 1, "R1 first grant");
      chk(empty === 1'b0, "R3 not empty", empty, 0);
      wr_std(3'd0, 32'h3A);           // data before address (R4)
      wr_sta(3'd0, 12'h3A);
      chk(dc_valid === 1'b0, "R7 not senior yet", dc_valid, 0);
      retire(7'd5, 7'd0, 3'b001);     // R5 oldest pointer
      chk(dc_valid === 1'b0, "R4 ptag missing", dc_valid, 0);
      wr_tlb(3'd0, 20'h3A);
      chk(dc_valid === 1'b1, "R5 senior and complete", dc_valid, 1);
      tick();                          // stall with dc_ready low (R7)
      chk(dc_valid === 1'b1 && dc_addr == 12'h3A, "R7 hold under stall", dc_addr, 12'h3A);
      expect_drain(8'h3A, "R7 drain");
      chk(empty === 1'b1, "R3 empty after drain", empty, 1);
   endtask

   task automatic t_pattern();
      logic [IDX_W-1:0] a, b;
      a = exp_tail; do_alloc(7'd10, 1, "R1 grant a");
      b = exp_tail; do_alloc(7'd11, 1, "R1 grant b");
      fill_all(b, 8'hB1); fill_all(a, 8'hA1);
      retire(7'd10, 7'd11, 3'b010);
      chk(dc_valid === 1'b0, "R6 pattern 010", dc_valid, 0);
      retire(7'd10, 7'd11, 3'b101);
      chk(dc_valid === 1'b0, "R6 pattern 101", dc_valid, 0);
      retire(7'd10, 7'd11, 3'b110);
      chk(dc_valid === 1'b0, "R6 pattern 110", dc_valid, 0);
      retire(7'd10, 7'd11, 3'b011);
      dc_ready = 1; #1;
      chk(dc_addr == 12'hA1, "R7 order first", dc_addr, 12'hA1);
      tick();
      chk(dc_valid === 1'b1 && dc_addr == 12'hB1, "R7 order second", dc_addr, 12'hB1);
      tick(); dc_ready = 0;
      chk(empty === 1'b1, "R7 one per cycle", empty, 1);
   endtask

   task automatic t_fence();
      logic [IDX_W-1:0] a;
      a = exp_tail; do_alloc(7'd20, 1, "R1 grant fence");
      fence_req = 1; #1;
      chk(fence_ok === 1'b0, "R8 fence blocked", fence_ok, 0);
      fill_all(a, 8'h20); retire(7'd20, 7'd0, 3'b111);
      #1; chk(fence_ok === 1'b0, "R8 fence until drained", fence_ok, 0);
      expect_drain(8'h20, "R8 drain before fence");
      #1; chk(fence_ok === 1'b1, "R8 fence granted", fence_ok, 1);
      fence_req = 0;
   endtask

   task automatic t_full_flush();
      logic [IDX_W-1:0] first;
      first = exp_tail;
      for (int i = 0; i < DEPTH; i++) do_alloc(7'(40 + i), 1, "R1 fill");
      chk(full === 1'b1, "R3 full", full, 1);
      do_alloc(7'd99, 0, "R3 no grant when full");
      fill_all(first, 8'h40); fill_all(first + 3'd1, 8'h41);
      fill_all(first + 3'd2, 8'h42);
      retire(7'd40, 7'd41, 3'b011);
      flush = 1; tick(); flush = 0;
      chk(full === 1'b0, "R9 flush frees", full, 0);
      alloc_ext_avail = 0;
      do_alloc(7'd60, 0, "R1 external resource missing");
      alloc_ext_avail = 1;
      exp_tail = first + 3'd2;
      do_alloc(7'd60, 1, "R9 tail after youngest senior");
      expect_drain(8'h40, "R9 senior drains 1");
      expect_drain(8'h41, "R9 senior drains 2");
      chk(dc_valid === 1'b0 && empty === 1'b0, "R9 new entry waits", dc_valid, 0);
      flush = 1; tick(); flush = 0;
      chk(empty === 1'b1, "R9 flush all speculative", empty, 1);
      exp_tail = first + 3'd2;
      do_alloc(7'd61, 1, "R1 grant reuse");
      flush = 1; tick(); flush = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_pattern();
      t_fence();
      t_full_flush();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule